// File: doc/BRIEF.md
# MSI Interrupt Request Sequencer

This block sits between user logic and the interrupt inputs of a PCI Express endpoint core. User logic hands it interrupt requests over a valid/ready port. Each request carries a function number, a vector index and three TLP attribute bits. The sequencer turns each accepted request into a single-cycle pulse on one bit of a 32-bit vector output. The function number and attributes are presented alongside the pulse. The sequencer then holds off further requests until the core answers with a sent pulse or a fail pulse.

On a fail pulse, the identical interrupt is issued again. Before issuing, the sequencer looks up the function's MSI enable bit and its 3-bit multiple-message-enable code from per-function configuration inputs. Requests for disabled or unknown functions are discarded and reported on a one-cycle drop strobe. Vector indices beyond the allocated count are folded into range by masking.

Top module: `msi_req_seq`

## Requirements
- R1: Each issued interrupt appears on `msi_vec` as exactly one set bit, held for exactly one clock cycle. The bit position equals the clipped vector index.
- R2: `msi_fn` and `msi_attr` carry the request's function number and attributes in the pulse cycle. Attribute bit 0 is No Snoop, bit 1 is Relaxed Ordering and bit 2 is ID-Based Ordering. Both outputs remain unchanged until the next request is accepted.
- R3: `req_ready` is high only when no interrupt is outstanding. After a pulse, no further pulse is issued until `msi_sent` or `msi_fail` is seen. A sent or fail pulse while idle has no effect.
- R4: When `msi_fail` is seen while an interrupt is outstanding, the same vector, function and attributes are pulsed again, two cycles after the fail cycle.
- R5: Function i reads its enable from `fn_en[i]` and its code from `fn_mme[3*i+2:3*i]`. Code c allows 2^c vectors for c = 0..5, and codes 6 and 7 allow 32. The index is ANDed with (allowed count - 1).
- R6: A request whose function number is at or above NUM_FN, or whose enable bit is low, is accepted but produces no pulse. It raises `req_drop` for one cycle, in the cycle after acceptance, and `req_ready` stays high.
- R7: If the fail pulse arrives after the outstanding function's enable has gone low, no reissue occurs. Instead `req_drop` pulses in the next cycle and the block returns to idle.
- R8: The vector pulse appears in the cycle directly after the cycle in which `req_valid` and `req_ready` are both high.
- R9: After reset, `msi_vec` is zero, `req_drop` is low and `req_ready` is high.
- R10: `msi_vec` is all-zero for at least one cycle between any two pulses, including a retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (idle) |
| req_fn | input | FN_W | Function number of the request |
| req_idx | input | IDX_W | Requested vector index |
| req_attr | input | 3 | TLP attributes (NS, RO, IDO) |
| fn_en | input | NUM_FN | Per-function MSI enable |
| fn_mme | input | 3*NUM_FN | Per-function multiple-message-enable codes |
| msi_vec | output | VEC_W | One-hot interrupt vector pulse to the core |
| msi_fn | output | FN_W | Function number presented with the pulse |
| msi_attr | output | 3 | Attributes presented with the pulse |
| msi_sent | input | 1 | Core reports message transmitted |
| msi_fail | input | 1 | Core reports message aborted |
| req_drop | output | 1 | One-cycle strobe: request or retry discarded |

## Verification
The main function is driven from a table that crosses every allocation code in use with indices inside and beyond the allowed count. This separates correct folding from plain decoding and from wrong mask widths. Attribute values differ per row, which exposes swapped or stale attribute capture. Rows that answer with a fail before the sent show whether the retry repeats the original request and leaves a zero gap. Directed cases cover a request held valid while busy, stray sent/fail pulses when idle, a reserved allocation code, an out-of-range function number, and an enable withdrawn before a fail. Together these distinguish handshake gating from drop handling.

// File: rtl/msi_seq_pkg.sv
package msi_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RETRY = 2'd2
  } seq_state_e;

  localparam int MME_W  = 3;
  localparam int ATTR_W = 3;

endpackage

// File: rtl/msi_fn_cfg.sv
module msi_fn_cfg #(
  parameter int NUM_FN = 4,
  parameter int FN_W   = 8,
  localparam int MME_W = msi_seq_pkg::MME_W
) (
  input  logic [FN_W-1:0]         fn,
  input  logic [NUM_FN-1:0]       en_all,
  input  logic [MME_W*NUM_FN-1:0] mme_all,
  output logic                    fn_en,
  output logic [MME_W-1:0]        fn_mme
);

  always_comb begin
    fn_en  = 1'b0;
    fn_mme = '0;
    for (int i = 0; i < NUM_FN; i++) begin
      if (fn == FN_W'(i)) begin
        fn_en  = en_all[i];
        fn_mme = mme_all[MME_W*i +: MME_W];
      end
    end
  end

endmodule

// File: rtl/msi_vec_map.sv
module msi_vec_map #(
  parameter int VEC_W = 32,
  localparam int IDX_W = $clog2(VEC_W),
  localparam int MME_W = msi_seq_pkg::MME_W
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [MME_W-1:0] mme,
  output logic [VEC_W-1:0] vec
);

  logic [IDX_W-1:0] mask;
  logic [IDX_W-1:0] clipped;

  // Allowed count is 2^code; count-1 has its low 'code' bits set.
  // Codes beyond IDX_W saturate to the full vector width.
  for (genvar i = 0; i < IDX_W; i++) begin : g_mask
    assign mask[i] = (int'(mme) > i);
  end

  assign clipped = idx & mask;

  for (genvar b = 0; b < VEC_W; b++) begin : g_dec
    assign vec[b] = (clipped == IDX_W'(b));
  end

endmodule

// File: rtl/msi_issue_ctl.sv
module msi_issue_ctl
  import msi_seq_pkg::*;
#(
  parameter int VEC_W = 32,
  parameter int FN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [FN_W-1:0]   req_fn,
  input  logic [ATTR_W-1:0] req_attr,
  input  logic              req_en,
  input  logic [VEC_W-1:0]  req_vec,
  input  logic              hold_en,
  input  logic              sent,
  input  logic              fail,
  output logic              ready,
  output logic [VEC_W-1:0]  vec,
  output logic [FN_W-1:0]   fn,
  output logic [ATTR_W-1:0] attr,
  output logic              drop
);

  seq_state_e        st_q;
  logic [VEC_W-1:0]  vec_q;
  logic [VEC_W-1:0]  save_q;
  logic [FN_W-1:0]   fn_q;
  logic [ATTR_W-1:0] attr_q;
  logic              drop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      vec_q  <= '0;
      save_q <= '0;
      fn_q   <= '0;
      attr_q <= '0;
      drop_q <= 1'b0;
    end else begin
      vec_q  <= '0;
      drop_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_en) begin
              fn_q   <= req_fn;
              attr_q <= req_attr;
              save_q <= req_vec;
              vec_q  <= req_vec;
              st_q   <= ST_WAIT;
            end else begin
              drop_q <= 1'b1;
            end
          end
        end
        ST_WAIT: begin
          if (fail) begin
            if (hold_en) begin
              st_q <= ST_RETRY;
            end else begin
              drop_q <= 1'b1;
              st_q   <= ST_IDLE;
            end
          end else if (sent) begin
            st_q <= ST_IDLE;
          end
        end
        ST_RETRY: begin
          vec_q <= save_q;
          st_q  <= ST_WAIT;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ready = (st_q == ST_IDLE);
  assign vec   = vec_q;
  assign fn    = fn_q;
  assign attr  = attr_q;
  assign drop  = drop_q;

  assert_vec_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vec_q));

  assert_pulse_width_R1: assert property (@(posedge clk) disable iff (rst)
    (|vec_q) |=> (vec_q == '0));

  assert_busy_blocks_R3: assert property (@(posedge clk) disable iff (rst)
    (|vec_q) |-> !ready);

  assert_hold_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !ready |=> ($stable(fn_q) && $stable(attr_q)));

  assert_retry_same_R4: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && fail && hold_en) |=> ##1 (vec_q == save_q && vec_q != '0));

  assert_drop_apart_R6: assert property (@(posedge clk) disable iff (rst)
    !(drop_q && (|vec_q)));

  assert_abandon_R7: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT && fail && !hold_en) |=> (drop_q && ready));

endmodule

// File: rtl/msi_req_seq.sv
module msi_req_seq #(
  parameter int NUM_FN = 4,
  parameter int FN_W   = 8,
  parameter int VEC_W  = 32,
  localparam int IDX_W = $clog2(VEC_W),
  localparam int MME_W = msi_seq_pkg::MME_W,
  localparam int ATTR_W = msi_seq_pkg::ATTR_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [FN_W-1:0]         req_fn,
  input  logic [IDX_W-1:0]        req_idx,
  input  logic [ATTR_W-1:0]       req_attr,
  input  logic [NUM_FN-1:0]       fn_en,
  input  logic [MME_W*NUM_FN-1:0] fn_mme,
  output logic [VEC_W-1:0]        msi_vec,
  output logic [FN_W-1:0]         msi_fn,
  output logic [ATTR_W-1:0]       msi_attr,
  input  logic                    msi_sent,
  input  logic                    msi_fail,
  output logic                    req_drop
);

  logic             rq_en;
  logic [MME_W-1:0] rq_mme;
  logic             hd_en;
  logic [MME_W-1:0] hd_mme;
  logic [VEC_W-1:0] rq_vec;

  msi_fn_cfg #(.NUM_FN(NUM_FN), .FN_W(FN_W)) u_cfg_req (
    .fn(req_fn), .en_all(fn_en), .mme_all(fn_mme),
    .fn_en(rq_en), .fn_mme(rq_mme)
  );

  msi_fn_cfg #(.NUM_FN(NUM_FN), .FN_W(FN_W)) u_cfg_hold (
    .fn(msi_fn), .en_all(fn_en), .mme_all(fn_mme),
    .fn_en(hd_en), .fn_mme(hd_mme)
  );

  msi_vec_map #(.VEC_W(VEC_W)) u_map (
    .idx(req_idx), .mme(rq_mme), .vec(rq_vec)
  );

  msi_issue_ctl #(.VEC_W(VEC_W), .FN_W(FN_W)) u_ctl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_fn(req_fn), .req_attr(req_attr),
    .req_en(rq_en), .req_vec(rq_vec), .hold_en(hd_en),
    .sent(msi_sent), .fail(msi_fail),
    .ready(req_ready), .vec(msi_vec), .fn(msi_fn), .attr(msi_attr),
    .drop(req_drop)
  );

  logic unused_hd;
  assign unused_hd = ^hd_mme;

endmodule

// File: tb/sim_msi_req_seq.sv
module sim_msi_req_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_fn = '0;
  logic [4:0]  req_idx = '0;
  logic [2:0]  req_attr = '0;
  logic [3:0]  fn_en = '0;
  logic [11:0] fn_mme = '0;
  logic [31:0] msi_vec;
  logic [7:0]  msi_fn;
  logic [2:0]  msi_attr;
  logic        msi_sent = 1'b0;
  logic        msi_fail = 1'b0;
  logic        req_drop;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  msi_req_seq u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_fn(req_fn), .req_idx(req_idx), .req_attr(req_attr),
    .fn_en(fn_en), .fn_mme(fn_mme), .msi_vec(msi_vec), .msi_fn(msi_fn),
    .msi_attr(msi_attr), .msi_sent(msi_sent), .msi_fail(msi_fail),
    .req_drop(req_drop)
  );

  typedef struct packed {
    logic [7:0]  fn;
    logic [4:0]  idx;
    logic [2:0]  attr;
    logic [3:0]  en;
    logic        fail1;
    logic [31:0] vec;
    logic        drop;
  } row_t;

  // codes: fn0=5 (32), fn1=0 (1), fn2=2 (4), fn3=3 (8)
  localparam logic [11:0] MME_SET = 12'b011_010_000_101;

  localparam row_t TBL [8] = '{
    '{8'd0, 5'd3,  3'd1, 4'b1111, 1'b0, 32'h0000_0008, 1'b0},
    '{8'd0, 5'd31, 3'd7, 4'b1111, 1'b1, 32'h8000_0000, 1'b0},
    '{8'd1, 5'd9,  3'd2, 4'b1111, 1'b0, 32'h0000_0001, 1'b0},
    '{8'd2, 5'd6,  3'd4, 4'b1111, 1'b1, 32'h0000_0004, 1'b0},
    '{8'd3, 5'd13, 3'd3, 4'b1111, 1'b0, 32'h0000_0020, 1'b0},
    '{8'd2, 5'd1,  3'd5, 4'b1011, 1'b0, 32'h0000_0000, 1'b1},
    '{8'd5, 5'd0,  3'd6, 4'b1111, 1'b0, 32'h0000_0000, 1'b1},
    '{8'd3, 5'd7,  3'd0, 4'b1111, 1'b1, 32'h0000_0080, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_row(input row_t t);
    fn_en     = t.en;
    req_fn    = t.fn;
    req_idx   = t.idx;
    req_attr  = t.attr;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (t.drop) begin
      chk(req_drop == 1'b1, "R6 drop strobe", 32'(req_drop), 32'd1);
      chk(msi_vec == '0, "R6 no pulse", msi_vec, 32'd0);
      chk(req_ready == 1'b1, "R6 ready stays", 32'(req_ready), 32'd1);
      @(negedge clk);
      chk(req_drop == 1'b0, "R6 strobe one cycle", 32'(req_drop), 32'd0);
    end else begin
      chk(msi_vec == t.vec, "R8 R5 R1 pulse vector", msi_vec, t.vec);
      chk(msi_fn == t.fn, "R2 function", 32'(msi_fn), 32'(t.fn));
      chk(msi_attr == t.attr, "R2 attributes", 32'(msi_attr), 32'(t.attr));
      chk(req_ready == 1'b0, "R3 busy", 32'(req_ready), 32'd0);
      if (t.fail1) begin
        msi_fail = 1'b1;
        @(negedge clk);
        msi_fail = 1'b0;
        chk(msi_vec == '0, "R10 gap before retry", msi_vec, 32'd0);
        @(negedge clk);
        chk(msi_vec == t.vec, "R4 retry vector", msi_vec, t.vec);
        chk(msi_fn == t.fn && msi_attr == t.attr, "R4 retry fields",
            {21'd0, msi_attr, msi_fn}, {21'd0, t.attr, t.fn});
      end else begin
        @(negedge clk);
        chk(msi_vec == '0, "R1 single cycle", msi_vec, 32'd0);
      end
      msi_sent = 1'b1;
      @(negedge clk);
      msi_sent = 1'b0;
      chk(req_ready == 1'b1, "R3 ready after sent", 32'(req_ready), 32'd1);
      chk(msi_vec == '0, "R10 idle zero", msi_vec, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    fn_mme = MME_SET;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(msi_vec == '0, "R9 vector zero", msi_vec, 32'd0);
    chk(req_drop == 1'b0, "R9 drop low", 32'(req_drop), 32'd0);
    chk(req_ready == 1'b1, "R9 ready high", 32'(req_ready), 32'd1);

    for (int i = 0; i < 8; i++) run_row(TBL[i]);

    // R3: stray sent / fail while idle have no effect
    msi_sent = 1'b1;
    @(negedge clk);
    msi_sent = 1'b0;
    msi_fail = 1'b1;
    @(negedge clk);
    msi_fail = 1'b0;
    chk(msi_vec == '0 && req_drop == 1'b0, "R3 idle ignores responses",
        msi_vec, 32'd0);
    @(negedge clk);
    chk(msi_vec == '0 && req_ready == 1'b1, "R3 idle stays idle",
        msi_vec, 32'd0);

    // R3: request held valid while busy is not taken until sent
    fn_en = 4'b1111;
    req_fn = 8'd0; req_idx = 5'd4; req_attr = 3'd2; req_valid = 1'b1;
    @(negedge clk);
    chk(msi_vec == 32'h10, "R1 first pulse", msi_vec, 32'h10);
    req_fn = 8'd3; req_idx = 5'd2; req_attr = 3'd6;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(msi_vec == '0 && req_ready == 1'b0, "R3 no issue while busy",
          msi_vec, 32'd0);
      chk(msi_fn == 8'd0 && msi_attr == 3'd2, "R2 held fields",
          {21'd0, msi_attr, msi_fn}, {21'd0, 3'd2, 8'd0});
    end
    msi_sent = 1'b1;
    @(negedge clk);
    msi_sent = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(msi_vec == 32'h4, "R3 second after sent", msi_vec, 32'h4);
    chk(msi_fn == 8'd3 && msi_attr == 3'd6, "R2 second fields",
        {21'd0, msi_attr, msi_fn}, {21'd0, 3'd6, 8'd3});
    msi_sent = 1'b1;
    @(negedge clk);
    msi_sent = 1'b0;

    // R5: reserved code 7 allows all 32 vectors
    fn_mme = {MME_SET[11:3], 3'b111};
    req_fn = 8'd0; req_idx = 5'd20; req_attr = 3'd0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(msi_vec == 32'h0010_0000, "R5 reserved code", msi_vec, 32'h0010_0000);
    msi_sent = 1'b1;
    @(negedge clk);
    msi_sent = 1'b0;
    fn_mme = MME_SET;

    // R7: enable withdrawn, then fail -> abandon with drop strobe
    req_fn = 8'd2; req_idx = 5'd1; req_attr = 3'd1; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(msi_vec == 32'h2, "R7 initial pulse", msi_vec, 32'h2);
    fn_en = 4'b1011;
    msi_fail = 1'b1;
    @(negedge clk);
    msi_fail = 1'b0;
    chk(req_drop == 1'b1, "R7 abandon strobe", 32'(req_drop), 32'd1);
    chk(req_ready == 1'b1, "R7 back to idle", 32'(req_ready), 32'd1);
    @(negedge clk);
    chk(msi_vec == '0 && req_drop == 1'b0, "R7 no reissue", msi_vec, 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule